// File: doc/BRIEF.md
# Power-Mode Clock Switchback Controller

This block owns the clock-divide mode of a small processor core. Software can put the core into a slow power-saving mode, where one internal cycle lasts 1024 input clocks. The block turns that mode into a clock-enable pulse stream: one pulse per input clock at full speed, and one pulse every 1024 input clocks in the slow mode. The divide mode itself is an output, so software can poll it.

When automatic switchback is enabled, a set of hardware events forces a return to full speed. Each event has its own timing:
- A qualified interrupt acknowledge takes effect at the next internal cycle boundary. If the instruction in progress writes an interrupt control register, it waits until a further instruction has completed.
- A write to a transmit buffer takes effect at the next instruction boundary.
- A falling edge on an enabled serial receive line takes effect as soon as the synchronised edge is seen. Noise also counts as an edge, and no error is reported.

Any hardware reset source also restores full speed. The interrupt controller, the serial datapaths and the instruction sequencer sit outside the block and reach it as strobes.

Top module: `clkdiv_switchback`

## Requirements
- R1: Asynchronous reset (`rstN` low), a watchdog reset strobe or an external reset strobe puts the block in full-speed mode (`divSlow`=0), with `clkEn`=1, from the cycle after the strobe.
- R2: In full-speed mode `clkEn` is 1 every cycle. A software write selecting slow mode (`modeWrEn`=1, `modeWrSlow`=1) sets `divSlow`=1 on the next cycle with a `clkEn` pulse in that cycle. Later pulses then come exactly every 1024 cycles.
- R3: A software write selecting full speed (`modeWrEn`=1, `modeWrSlow`=0) clears `divSlow` on the next cycle.
- R4: While `swbEnable`=0, no interrupt, transmit or receive event leaves slow mode. Events seen while disabled are discarded and do not fire after the enable is set again.
- R5: An `irqAck` strobe in slow mode, with `irqDefer`=0, clears `divSlow` in the cycle after the first `clkEn` pulse that lies strictly after the strobe cycle.
- R6: An `irqAck` strobe given with `irqDefer`=1 is held until two `instrDone` strobes have followed it. It then fires at the next `clkEn` pulse, with the same timing as R5.
- R7: A high-to-low transition on `rxLine[i]` while `rxEnable[i]`=1 clears `divSlow` three cycles after the line changes (two synchroniser stages plus edge detection). With `rxEnable[i]`=0 the transition has no effect.
- R8: A `txLoad` strobe in slow mode clears `divSlow` in the cycle after the first `instrDone` strobe that occurs in or after the load cycle.
- R9: After any switchback the divide counter restarts, so `clkEn` is 1 in every cycle from the first full-speed cycle on.
- R10: A switchback event wins over a software write selecting slow mode in the same cycle.
- R11: Interrupt and transmit events seen in full-speed mode leave no pending request behind. They cause no exit after slow mode is entered later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Undivided input clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| wdtRst | input | 1 | Watchdog reset strobe, synchronous |
| extRst | input | 1 | External reset strobe, synchronous |
| swbEnable | input | 1 | Automatic switchback enable |
| modeWrEn | input | 1 | Software mode-select write strobe |
| modeWrSlow | input | 1 | Written mode value: 1 selects slow mode, 0 selects full speed |
| irqAck | input | NUM_IRQ | Qualified interrupt acknowledge strobes, one per external line |
| irqDefer | input | 1 | Current instruction writes an interrupt enable or priority register |
| instrDone | input | 1 | Instruction completion strobe |
| txLoad | input | NUM_PORTS | Transmit buffer write strobes, one per serial port |
| rxEnable | input | NUM_PORTS | Receiver enable bits, one per serial port |
| rxLine | input | NUM_PORTS | Asynchronous serial receive lines, idle high |
| divSlow | output | 1 | Current divide mode, 1 = slow; also the software status readback |
| clkEn | output | 1 | Internal-cycle clock-enable pulse |

## Verification
The hardest cases to reach are the deferred interrupt and the stale-event cases. In both, the outcome depends on where strobes land relative to `clkEn` pulses that are 1024 cycles apart. The bench first enters slow mode, which aligns the divider to a known cycle. It then counts negative edges from there. This lets it place the second `instrDone` of a deferred acknowledge after the first pulse boundary, so that only the following boundary may release it. It also lets it place events while switchback is disabled, or while in full speed, so that any wrongly kept request would fire within the observed window.

// File: rtl/swb_pkg.sv
package swb_pkg;
  // Strobes from the mode control to the divider datapath
  typedef struct packed {
    logic slow;   // registered slow-mode flag
    logic clear;  // leaving slow mode at the next edge: restart divider
  } dpCtrl_t;
endpackage

// File: rtl/swb_datapath.sv
module swb_datapath
  import swb_pkg::*;
#(
  parameter int DIV_BITS  = 10,
  parameter int NUM_PORTS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtrl_t              ctl,
  input  logic [NUM_PORTS-1:0] rxLine,
  output logic                 clkEn,
  output logic [NUM_PORTS-1:0] rxFall
);
  localparam int SyncStages = 3;

  logic [DIV_BITS-1:0] divCnt;

  // Divider: held at zero in full speed, free-running in slow mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      divCnt <= '0;
    else if (ctl.clear || !ctl.slow) divCnt <= '0;
    else                            divCnt <= divCnt + 1'b1;
  end

  assign clkEn = !ctl.slow || (divCnt == '0);

  // Per-port receive synchroniser and falling-edge detector on the raw clock
  for (genvar p = 0; p < NUM_PORTS; p++) begin : gRx
    logic [SyncStages-1:0] syncQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ <= '1;
      else       syncQ <= {syncQ[SyncStages-2:0], rxLine[p]};
    end
    assign rxFall[p] = syncQ[SyncStages-1] & ~syncQ[SyncStages-2];
  end
endmodule

// File: rtl/swb_ctrl.sv
module swb_ctrl
  import swb_pkg::*;
#(
  parameter int NUM_IRQ   = 6,
  parameter int NUM_PORTS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wdtRst,
  input  logic                 extRst,
  input  logic                 swbEnable,
  input  logic                 modeWrEn,
  input  logic                 modeWrSlow,
  input  logic [NUM_IRQ-1:0]   irqAck,
  input  logic                 irqDefer,
  input  logic                 instrDone,
  input  logic [NUM_PORTS-1:0] txLoad,
  input  logic [NUM_PORTS-1:0] rxEnable,
  input  logic [NUM_PORTS-1:0] rxFall,
  input  logic                 clkEn,
  output dpCtrl_t              ctl
);
  localparam int WaitBits = 2;
  localparam logic [WaitBits-1:0] DeferDepth = WaitBits'(2);

  logic                slowQ;
  logic                irqPend;
  logic                txPend;
  logic [WaitBits-1:0] irqWait;

  logic armed, hwReset, anyAck, anyLoad;
  logic irqFire, txFire, rxFire, wake, dropPend, waitStep;

  assign armed    = slowQ && swbEnable;
  assign hwReset  = wdtRst || extRst;
  assign anyAck   = |irqAck;
  assign anyLoad  = |txLoad;

  assign irqFire  = irqPend && (irqWait == '0) && clkEn;
  assign txFire   = (txPend || anyLoad) && instrDone;
  assign rxFire   = |(rxFall & rxEnable);
  assign wake     = armed && (irqFire || txFire || rxFire);
  assign dropPend = hwReset || wake || !armed;
  assign waitStep = instrDone && (irqWait != '0);

  // Divide mode register: reset, then switchback, then software write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         slowQ <= 1'b0;
    else if (hwReset)  slowQ <= 1'b0;
    else if (wake)     slowQ <= 1'b0;
    else if (modeWrEn) slowQ <= modeWrSlow;
  end

  // Interrupt request with deferral across instruction boundaries
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPend <= 1'b0;
      irqWait <= '0;
    end else if (dropPend) begin
      irqPend <= 1'b0;
      irqWait <= '0;
    end else begin
      if (anyAck) irqPend <= 1'b1;
      if (anyAck && irqDefer)     irqWait <= DeferDepth;
      else if (anyAck && !irqPend) irqWait <= '0;
      else if (waitStep)          irqWait <= irqWait - 1'b1;
    end
  end

  // Transmit request waits for the instruction boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         txPend <= 1'b0;
    else if (dropPend) txPend <= 1'b0;
    else if (anyLoad)  txPend <= 1'b1;
  end

  assign ctl.slow  = slowQ;
  assign ctl.clear = hwReset || wake || (modeWrEn && !modeWrSlow);
endmodule

// File: rtl/clkdiv_switchback.sv
module clkdiv_switchback
  import swb_pkg::*;
#(
  parameter int DIV_BITS  = 10,
  parameter int NUM_IRQ   = 6,
  parameter int NUM_PORTS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wdtRst,
  input  logic                 extRst,
  input  logic                 swbEnable,
  input  logic                 modeWrEn,
  input  logic                 modeWrSlow,
  input  logic [NUM_IRQ-1:0]   irqAck,
  input  logic                 irqDefer,
  input  logic                 instrDone,
  input  logic [NUM_PORTS-1:0] txLoad,
  input  logic [NUM_PORTS-1:0] rxEnable,
  input  logic [NUM_PORTS-1:0] rxLine,
  output logic                 divSlow,
  output logic                 clkEn
);
  dpCtrl_t              ctl;
  logic [NUM_PORTS-1:0] rxFall;

  swb_ctrl #(.NUM_IRQ(NUM_IRQ), .NUM_PORTS(NUM_PORTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wdtRst(wdtRst), .extRst(extRst),
    .swbEnable(swbEnable), .modeWrEn(modeWrEn), .modeWrSlow(modeWrSlow),
    .irqAck(irqAck), .irqDefer(irqDefer), .instrDone(instrDone),
    .txLoad(txLoad), .rxEnable(rxEnable), .rxFall(rxFall),
    .clkEn(clkEn), .ctl(ctl)
  );

  swb_datapath #(.DIV_BITS(DIV_BITS), .NUM_PORTS(NUM_PORTS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxLine(rxLine),
    .clkEn(clkEn), .rxFall(rxFall)
  );

  assign divSlow = ctl.slow;
endmodule

// File: rtl/swb_checker.sv
module swb_checker #(
  parameter int DIV_BITS  = 10,
  parameter int NUM_PORTS = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wdtRst,
  input logic                 extRst,
  input logic                 swbEnable,
  input logic                 modeWrEn,
  input logic                 modeWrSlow,
  input logic                 instrDone,
  input logic [NUM_PORTS-1:0] txLoad,
  input logic                 divSlow,
  input logic                 clkEn
);
  localparam int GapBits = DIV_BITS + 1;
  localparam logic [GapBits-1:0] GapMax  = '1;
  localparam logic [GapBits-1:0] GapWant = GapBits'((1 << DIV_BITS) - 1);

  logic [GapBits-1:0] gapCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 gapCnt <= '0;
    else if (clkEn)            gapCnt <= '0;
    else if (gapCnt != GapMax) gapCnt <= gapCnt + 1'b1;
  end

  AST_HWRESET_FAST: assert property (@(posedge clk) disable iff (!rstN)
    (wdtRst || extRst) |=> (!divSlow && clkEn)); // R1
  AST_SLOW_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (modeWrEn && modeWrSlow && !divSlow && !wdtRst && !extRst) |=> (divSlow && clkEn)); // R2
  AST_SLOW_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (divSlow && $past(divSlow) && clkEn) |-> (gapCnt == GapWant)); // R2
  AST_SW_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (modeWrEn && !modeWrSlow) |=> !divSlow); // R3
  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (divSlow && !swbEnable && !modeWrEn && !wdtRst && !extRst) |=> divSlow); // R4
  AST_TX_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    (divSlow && swbEnable && (|txLoad) && instrDone) |=> !divSlow); // R8
endmodule

bind clkdiv_switchback swb_checker #(.DIV_BITS(DIV_BITS), .NUM_PORTS(NUM_PORTS)) u_chk (
  .clk(clk), .rstN(rstN), .wdtRst(wdtRst), .extRst(extRst),
  .swbEnable(swbEnable), .modeWrEn(modeWrEn), .modeWrSlow(modeWrSlow),
  .instrDone(instrDone), .txLoad(txLoad), .divSlow(divSlow), .clkEn(clkEn)
);

// File: tb/clkdiv_switchback_test.sv
`timescale 1ns/1ps
module clkdiv_switchback_test;
  localparam int NIRQ  = 6;
  localparam int NPORT = 2;
  localparam int SLOWP = 1024;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wdtRst = 0, extRst = 0, swbEnable = 0, modeWrEn = 0, modeWrSlow = 0;
  logic [NIRQ-1:0]  irqAck = '0;
  logic irqDefer = 0, instrDone = 0;
  logic [NPORT-1:0] txLoad = '0, rxEnable = '0, rxLine = '1;
  logic divSlow, clkEn;

  int testsRun = 0, testsFailed = 0;
  bit finished = 0;

  always #10 clk = ~clk; // 50 MHz

  clkdiv_switchback uut (
    .clk(clk), .rstN(rstN), .wdtRst(wdtRst), .extRst(extRst),
    .swbEnable(swbEnable), .modeWrEn(modeWrEn), .modeWrSlow(modeWrSlow),
    .irqAck(irqAck), .irqDefer(irqDefer), .instrDone(instrDone),
    .txLoad(txLoad), .rxEnable(rxEnable), .rxLine(rxLine),
    .divSlow(divSlow), .clkEn(clkEn)
  );

  task automatic check(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Enter slow mode; returns at the first slow-mode negedge (clkEn pulse)
  task automatic goSlow();
    @(negedge clk); modeWrEn = 1; modeWrSlow = 1;
    @(negedge clk); modeWrEn = 0; modeWrSlow = 0;
  endtask

  task automatic goFast();
    @(negedge clk); modeWrEn = 1; modeWrSlow = 0;
    @(negedge clk); modeWrEn = 0;
  endtask

  // Count negedges until divSlow drops (bounded)
  task automatic countToFast(input int limit, output int n);
    n = 0;
    while (divSlow && n < limit) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic testReset();
    check("R1 divSlow in reset", int'(divSlow), 0);
    check("R1 clkEn in reset", int'(clkEn), 1);
    @(negedge clk); rstN = 1;
    @(negedge clk);
    check("R2 clkEn full speed", int'(clkEn), 1);
    goSlow(); repeat (4) @(negedge clk);
    wdtRst = 1; @(negedge clk); wdtRst = 0;
    check("R1 watchdog reset", int'(divSlow), 0);
    check("R1 clkEn after watchdog", int'(clkEn), 1);
    goSlow(); repeat (4) @(negedge clk);
    extRst = 1; @(negedge clk); extRst = 0;
    check("R1 external reset", int'(divSlow), 0);
  endtask

  task automatic testDivide();
    int gap;
    goSlow();
    check("R2 slow after write", int'(divSlow), 1);
    check("R2 pulse on entry", int'(clkEn), 1);
    @(negedge clk);
    check("R2 no pulse next cycle", int'(clkEn), 0);
    gap = 1;
    while (!clkEn && gap < 3000) begin @(negedge clk); gap++; end
    check("R2 slow pulse spacing", gap, SLOWP);
    repeat (4) @(negedge clk);
    modeWrEn = 1; modeWrSlow = 0; @(negedge clk); modeWrEn = 0;
    check("R3 software exit", int'(divSlow), 0);
  endtask

  task automatic testIrq();
    int n;
    swbEnable = 1;
    goSlow();
    irqAck[0] = 1; @(negedge clk); irqAck[0] = 0;
    n = 1; while (divSlow && n < 3000) begin @(negedge clk); n++; end
    check("R5 ack on pulse cycle", n, SLOWP + 1);
    goSlow(); repeat (4) @(negedge clk);
    irqAck[5] = 1; @(negedge clk); irqAck[5] = 0;
    n = 1; while (divSlow && n < 3000) begin @(negedge clk); n++; end
    check("R5 ack mid cycle", n, SLOWP - 3);
    for (int k = 0; k < 3; k++) begin
      check("R9 clkEn every cycle after wake", int'(clkEn), 1);
      @(negedge clk);
    end
  endtask

  task automatic testDefer();
    int k;
    goSlow(); repeat (4) @(negedge clk);
    irqAck[2] = 1; irqDefer = 1;
    k = 0;
    while (divSlow && k < 5000) begin
      @(negedge clk); k++;
      irqAck[2] = 0; irqDefer = 0;
      instrDone = (k == 5) || (k == 1025);
    end
    instrDone = 0;
    check("R6 deferred ack released one boundary later", k, 2 * SLOWP - 3);
  endtask

  task automatic testRx();
    int n;
    rxEnable = 2'b01;
    goSlow(); repeat (4) @(negedge clk);
    rxLine[0] = 0;
    countToFast(50, n);
    check("R7 rx edge port 0 latency", n, 3);
    rxLine[0] = 1; repeat (4) @(negedge clk);
    goSlow(); repeat (4) @(negedge clk);
    rxLine[1] = 0;
    countToFast(40, n);
    check("R7 rx edge disabled port ignored", int'(divSlow), 1);
    rxLine[1] = 1; repeat (4) @(negedge clk);
    rxEnable = 2'b11;
    rxLine[1] = 0;
    countToFast(50, n);
    check("R7 rx edge port 1 latency", n, 3);
    rxLine[1] = 1; repeat (4) @(negedge clk);
  endtask

  task automatic testTx();
    int n;
    goSlow(); repeat (4) @(negedge clk);
    txLoad[1] = 1; @(negedge clk); txLoad[1] = 0;
    @(negedge clk); @(negedge clk);
    check("R8 no exit before boundary", int'(divSlow), 1);
    instrDone = 1; @(negedge clk); instrDone = 0;
    check("R8 exit after boundary", int'(divSlow), 0);
    goSlow(); repeat (4) @(negedge clk);
    txLoad[0] = 1; instrDone = 1; @(negedge clk); txLoad[0] = 0; instrDone = 0;
    check("R8 load on boundary cycle", int'(divSlow), 0);
  endtask

  task automatic testPriority();
    goSlow(); repeat (4) @(negedge clk);
    txLoad[0] = 1; instrDone = 1; modeWrEn = 1; modeWrSlow = 1;
    @(negedge clk);
    txLoad[0] = 0; instrDone = 0; modeWrEn = 0; modeWrSlow = 0;
    check("R10 wake beats slow write", int'(divSlow), 0);
  endtask

  task automatic testDisabled();
    int n;
    swbEnable = 0;
    goSlow(); repeat (4) @(negedge clk);
    irqAck[1] = 1; txLoad[0] = 1; instrDone = 1; rxLine[0] = 0;
    @(negedge clk); irqAck[1] = 0; txLoad[0] = 0; instrDone = 0;
    countToFast(1100, n);
    check("R4 disabled stays slow", int'(divSlow), 1);
    swbEnable = 1; rxLine[0] = 1;
    repeat (3) @(negedge clk);
    instrDone = 1; @(negedge clk); instrDone = 0;
    countToFast(1100, n);
    check("R4 discarded events stay discarded", int'(divSlow), 1);
    goFast();
  endtask

  task automatic testStale();
    int n;
    @(negedge clk); irqAck[3] = 1; txLoad[1] = 1;
    @(negedge clk); irqAck[3] = 0; txLoad[1] = 0;
    goSlow(); repeat (10) @(negedge clk);
    instrDone = 1; @(negedge clk); instrDone = 0;
    countToFast(1100, n);
    check("R11 no stale request", int'(divSlow), 1);
    goFast();
  endtask

  initial begin
    #(20.0 * 200000);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    testDivide();
    testIrq();
    testDefer();
    testRx();
    testTx();
    testPriority();
    testDisabled();
    testStale();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule